// File: doc/BRIEF.md
# Serial Clock and Timer Tick Generator

This block derives the serial clock of a synchronous serial port, with the matching data sample and data shift strobes, from the system clock. A power-of-two prescaler first slows the system clock. A phase counter then holds the serial clock in its low level for one programmable number of scaled periods and in its high level for another, so the duty cycle can be set freely. A polarity input sets the level the clock rests at. A phase input picks whether data is sampled on the leading or the trailing edge of each clock pulse. A run input, driven by the transaction sequencer, starts and stops the clock.

When the timer mode input is set, the block stops making a serial clock. It joins the two 8-bit count inputs into one 16-bit reload value and emits a one-cycle tick each time that many scaled periods have passed. Both modes share the prescaler and a single 16-bit counter.

Top module: `sclk_gen`

## Requirements
- R1: While `runEn` is low, `sclkOut` equals `cpol` from the next clock edge on, and `sampleStb`, `shiftStb` and `timerTick` stay low. After reset, all outputs are low.
- R2: The scaled clock runs at the system clock divided by 2^`scaleSel`. Every phase length and timer period below is counted in scaled periods and so is multiplied by 2^`scaleSel` in system clock cycles.
- R3: A `scaleSel` value above 8 divides by 256, exactly as the value 8 does.
- R4: In clock mode, `sclkOut` stays low for `loCnt`×2^s system cycles and high for `hiCnt`×2^s system cycles, and the two counts are independent.
- R5: A count of 0 acts as 1. This applies to `loCnt` and `hiCnt` in clock mode and to a 16-bit reload of 0 in timer mode.
- R6: The first transition of `sclkOut` comes exactly one full idle-level phase after `runEn` rises. Counted in `runEn`-high clock edges, the new level shows after edge N, where N is that phase length in system cycles. This holds again after a stop taken in mid-phase.
- R7: With `cpol`=1 the clock rests high, so its first phase is a high phase and lasts `hiCnt`×2^s. With `cpol`=0 the first phase is a low phase and lasts `loCnt`×2^s.
- R8: A leading edge is a transition that leaves the idle level; a trailing edge is one that returns to it. With `cpha`=0, `sampleStb` pulses on leading edges and `shiftStb` on trailing edges. With `cpha`=1 the two are swapped. Each strobe lasts one cycle, the two never pulse together, and a strobe appears in the same cycle that `sclkOut` first shows the new level.
- R9: With `timerMode`=1 and `runEn`=1, the reload value is {`hiCnt`,`loCnt`} (`hiCnt` is bits 15:8). `timerTick` pulses for one cycle every reload×2^s system cycles, the first one after that many `runEn`-high edges. `sclkOut` stays at `cpol`, and no sample or shift strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| runEn | input | 1 | Run gate from the transaction sequencer |
| timerMode | input | 1 | 1 = periodic tick timer, 0 = serial clock |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| scaleSel | input | 4 | Prescaler exponent; values above 8 are clamped to 8 |
| loCnt | input | 8 | Low-phase length; timer reload bits 7:0 |
| hiCnt | input | 8 | High-phase length; timer reload bits 15:8 |
| sclkOut | output | 1 | Serial clock |
| sampleStb | output | 1 | One-cycle data sample strobe |
| shiftStb | output | 1 | One-cycle data shift strobe |
| timerTick | output | 1 | One-cycle periodic tick in timer mode |

## Verification
A wrong prescaler or phase count shows up at the first serial clock transition after `runEn` rises: that edge lands early or late by whole multiples of 2^s cycles, and the error then repeats at every following edge. A level register that has lost track of the idle level swaps the sample and shift strobes from the first pulse onward. A counter that is not cleared on stop shows as a short first phase on the next run. Each of these appears within one clock period of the run start, so every event is checked against its expected system cycle, level and strobe pattern.

// File: rtl/sclk_pkg.sv
`timescale 1ns/1ps
package sclk_pkg;

  // Control strobes passed from the sequencer to the counting datapath.
  typedef struct packed {
    logic clr;       // hold counter at zero
    logic step;      // one scaled clock period elapsed
    logic selHi;     // current level is high: compare against high count
    logic timerSel;  // compare against the joined 16-bit reload
  } sclkCtrl_t;

  // Clamp the prescaler exponent to the largest supported value.
  function automatic logic [3:0] clampScale(input logic [3:0] s, input int maxS);
    clampScale = (int'(s) > maxS) ? 4'(maxS) : s;
  endfunction

endpackage

// File: rtl/sclk_dp.sv
`timescale 1ns/1ps
module sclk_dp
  import sclk_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  sclkCtrl_t        ctl,
  input  logic [CNT_W-1:0] loCnt,
  input  logic [CNT_W-1:0] hiCnt,
  output logic             done
);
  localparam int TMR_W = 2 * CNT_W;

  logic [TMR_W-1:0] cnt;
  logic [TMR_W-1:0] rawLimit;
  logic [TMR_W-1:0] limit;
  logic [TMR_W:0]   nextCnt;

  // Pick the terminal count for the current phase or the timer reload.
  always_comb begin
    if (ctl.timerSel)   rawLimit = {hiCnt, loCnt};
    else if (ctl.selHi) rawLimit = TMR_W'(hiCnt);
    else                rawLimit = TMR_W'(loCnt);
    limit   = (rawLimit == '0) ? TMR_W'(1) : rawLimit;
    nextCnt = {1'b0, cnt} + (TMR_W+1)'(1);
    done    = ctl.step && (nextCnt >= {1'b0, limit});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cnt <= '0;
    else if (ctl.clr)  cnt <= '0;
    else if (done)     cnt <= '0;
    else if (ctl.step) cnt <= nextCnt[TMR_W-1:0];
  end

endmodule

// File: rtl/sclk_ctrl.sv
`timescale 1ns/1ps
module sclk_ctrl
  import sclk_pkg::*;
#(
  parameter int SCALE_W   = 4,
  parameter int MAX_SCALE = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               runEn,
  input  logic               timerMode,
  input  logic               cpol,
  input  logic               cpha,
  input  logic [SCALE_W-1:0] scaleSel,
  input  logic               done,
  output sclkCtrl_t          ctl,
  output logic               sclkOut,
  output logic               sampleStb,
  output logic               shiftStb,
  output logic               timerTick
);
  localparam int PRE_W = (MAX_SCALE < 1) ? 1 : MAX_SCALE;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;
  logic [PRE_W:0]   maskWide;
  logic [3:0]       sEff;
  logic             preHit;
  logic             lvl;
  logic             leading;
  logic             sampleNow;

  // Prescaler: a hit every 2^sEff cycles while running.
  always_comb begin
    sEff     = clampScale(4'(scaleSel), MAX_SCALE);
    maskWide = ((PRE_W+1)'(1) << sEff) - (PRE_W+1)'(1);
    preMask  = maskWide[PRE_W-1:0];
    preHit   = runEn && ((preCnt & preMask) == preMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       preCnt <= '0;
    else if (!runEn) preCnt <= '0;
    else if (preHit) preCnt <= '0;
    else             preCnt <= preCnt + PRE_W'(1);
  end

  always_comb begin
    ctl.clr      = !runEn;
    ctl.step     = preHit;
    ctl.selHi    = lvl;
    ctl.timerSel = timerMode;
    leading      = (lvl == cpol);
    sampleNow    = leading ^ cpha;
  end

  // Level register and one-cycle strobes, aligned with the new level.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvl       <= 1'b0;
      sampleStb <= 1'b0;
      shiftStb  <= 1'b0;
      timerTick <= 1'b0;
    end else begin
      sampleStb <= 1'b0;
      shiftStb  <= 1'b0;
      timerTick <= 1'b0;
      if (!runEn) begin
        lvl <= cpol;
      end else if (timerMode) begin
        lvl       <= cpol;
        timerTick <= done;
      end else if (done) begin
        lvl       <= !lvl;
        sampleStb <= sampleNow;
        shiftStb  <= !sampleNow;
      end
    end
  end

  assign sclkOut = lvl;

endmodule

// File: rtl/sclk_gen.sv
`timescale 1ns/1ps
module sclk_gen
  import sclk_pkg::*;
#(
  parameter int SCALE_W   = 4,
  parameter int MAX_SCALE = 8,
  parameter int CNT_W     = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               runEn,
  input  logic               timerMode,
  input  logic               cpol,
  input  logic               cpha,
  input  logic [SCALE_W-1:0] scaleSel,
  input  logic [CNT_W-1:0]   loCnt,
  input  logic [CNT_W-1:0]   hiCnt,
  output logic               sclkOut,
  output logic               sampleStb,
  output logic               shiftStb,
  output logic               timerTick
);
  sclkCtrl_t ctl;
  logic      done;

  sclk_ctrl #(.SCALE_W(SCALE_W), .MAX_SCALE(MAX_SCALE)) ctrl_i (
    .clk(clk), .rstN(rstN), .runEn(runEn), .timerMode(timerMode),
    .cpol(cpol), .cpha(cpha), .scaleSel(scaleSel), .done(done),
    .ctl(ctl), .sclkOut(sclkOut), .sampleStb(sampleStb),
    .shiftStb(shiftStb), .timerTick(timerTick)
  );

  sclk_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .loCnt(loCnt), .hiCnt(hiCnt), .done(done)
  );

endmodule

// File: rtl/sclk_gen_chk.sv
`timescale 1ns/1ps
module sclk_gen_chk (
  input logic clk,
  input logic rstN,
  input logic runEn,
  input logic timerMode,
  input logic cpol,
  input logic sclkOut,
  input logic sampleStb,
  input logic shiftStb,
  input logic timerTick
);
  // R1
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> sclkOut == $past(cpol));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (!sampleStb && !shiftStb && !timerTick));

  // R8
  strobe_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb || shiftStb) |-> sclkOut != $past(sclkOut));

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleStb && shiftStb));

  // R9
  timer_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    timerMode |=> (!sampleStb && !shiftStb));

  // R9
  timer_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timerMode && runEn) |=> sclkOut == $past(cpol));

  // R9
  tick_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    timerTick |-> $past(timerMode && runEn));
endmodule

bind sclk_gen sclk_gen_chk chk_i (
  .clk(clk), .rstN(rstN), .runEn(runEn), .timerMode(timerMode),
  .cpol(cpol), .sclkOut(sclkOut), .sampleStb(sampleStb),
  .shiftStb(shiftStb), .timerTick(timerTick)
);

// File: tb/sclk_gen_tb.sv
`timescale 1ns/1ps
module sclk_gen_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       runEn = 1'b0;
  logic       timerMode = 1'b0;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic [3:0] scaleSel = '0;
  logic [7:0] loCnt = 8'd1;
  logic [7:0] hiCnt = 8'd1;
  logic       sclkOut, sampleStb, shiftStb, timerTick;

  always #10 clk = ~clk;  // 50 MHz

  sclk_gen dut_i (
    .clk(clk), .rstN(rstN), .runEn(runEn), .timerMode(timerMode),
    .cpol(cpol), .cpha(cpha), .scaleSel(scaleSel), .loCnt(loCnt),
    .hiCnt(hiCnt), .sclkOut(sclkOut), .sampleStb(sampleStb),
    .shiftStb(shiftStb), .timerTick(timerTick)
  );

  typedef struct {
    int    cyc;
    bit    lvl;
    bit    smp;
    bit    shf;
    bit    tck;
    string req;
  } evt_t;

  evt_t  expQ[$];
  int    nChk = 0;
  int    nErr = 0;
  int    edgeCnt = 0;
  bit    monOn = 0;
  logic  prevSclk = 1'b0;
  bit    finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  endtask

  // Edges seen with runEn high since it rose.
  always @(posedge clk) begin
    if (runEn) edgeCnt <= edgeCnt + 1;
    else       edgeCnt <= 0;
  end

  // Monitor: every output event is popped and compared.
  always @(negedge clk) begin : monitor
    evt_t e;
    if (monOn && (sclkOut !== prevSclk || sampleStb || shiftStb || timerTick)) begin
      if (expQ.size() == 0) begin
        chk(0, "R8", "unexpected output event at cycle", edgeCnt, -1);
      end else begin
        e = expQ.pop_front();
        chk(edgeCnt == e.cyc, e.req, "event cycle", edgeCnt, e.cyc);
        chk(sclkOut == e.lvl, e.req, "sclk level", int'(sclkOut), int'(e.lvl));
        chk(sampleStb == e.smp && shiftStb == e.shf, "R8",
            "strobes {sample,shift}", int'({sampleStb, shiftStb}),
            int'({e.smp, e.shf}));
        chk(timerTick == e.tck, "R9", "timer tick", int'(timerTick), int'(e.tck));
      end
    end
    prevSclk = sclkOut;
  end

  // Driver: configure, push expected events, run, stop mid-phase.
  task automatic runCase(input bit pol, input bit pha, input bit tmr,
                         input int s, input int lo, input int hi,
                         input int nEv, input string req);
    int sE, loE, hiE, rel, t, guard;
    bit lv;
    @(negedge clk);
    monOn = 0;
    runEn = 0;
    cpol = pol; cpha = pha; timerMode = tmr;
    scaleSel = 4'(s); loCnt = 8'(lo); hiCnt = 8'(hi);
    repeat (3) @(negedge clk);
    // R1: idle level and quiet strobes before the run
    chk(sclkOut == pol && !sampleStb && !shiftStb && !timerTick, "R1",
        "idle outputs {sclk,smp,shf,tick}",
        int'({sclkOut, sampleStb, shiftStb, timerTick}), int'({pol, 3'b000}));
    sE  = (s > 8) ? 8 : s;
    loE = (lo == 0) ? 1 : lo;
    hiE = (hi == 0) ? 1 : hi;
    t = 0;
    lv = pol;
    if (tmr) begin
      rel = (hi * 256) + lo;
      if (rel == 0) rel = 1;
      for (int k = 0; k < nEv; k++) begin
        t += rel << sE;
        expQ.push_back('{t, pol, 1'b0, 1'b0, 1'b1, req});
      end
    end else begin
      for (int k = 0; k < nEv; k++) begin
        bit lead, smp;
        t += (lv ? hiE : loE) << sE;
        lv = !lv;
        lead = (k % 2 == 0);
        smp = lead ? !pha : pha;
        expQ.push_back('{t, lv, smp, !smp, 1'b0, req});
      end
    end
    monOn = 1;
    runEn = 1;
    guard = 0;
    while (expQ.size() > 0 && guard < t + 20) begin
      @(negedge clk);
      guard++;
    end
    chk(expQ.size() == 0, req, "events missing", expQ.size(), 0);
    expQ.delete();
    monOn = 0;
    @(negedge clk);
    runEn = 0;
    repeat (2) @(negedge clk);
    // R1: back at idle after the stop
    chk(sclkOut == pol && !sampleStb && !shiftStb && !timerTick, "R1",
        "outputs after stop", int'({sclkOut, sampleStb, shiftStb, timerTick}),
        int'({pol, 3'b000}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sclkOut == 0 && !sampleStb && !shiftStb && !timerTick, "R1",
        "reset outputs", int'({sclkOut, sampleStb, shiftStb, timerTick}), 0);
    rstN = 1;
    // R4 R6 R8: cpol 0, cpha 0, uneven duty
    runCase(0, 0, 0, 0, 2, 3, 6, "R4");
    // R6: repeat after a stop, first phase full length again
    runCase(0, 0, 0, 0, 2, 3, 3, "R6");
    // R2 R8: prescale by 4, cpha 1
    runCase(0, 1, 0, 2, 1, 4, 6, "R2");
    // R7: idle high, first phase uses the high count
    runCase(1, 0, 0, 1, 3, 1, 5, "R7");
    // R7 R8: idle high with cpha 1
    runCase(1, 1, 0, 0, 2, 5, 4, "R7");
    // R5: zero counts act as one
    runCase(0, 0, 0, 0, 0, 0, 6, "R5");
    // R3: scale 12 clamps to 256
    runCase(0, 0, 0, 12, 1, 1, 3, "R3");
    // R9: 16-bit reload {1,2} = 258
    runCase(0, 0, 1, 0, 2, 1, 3, "R9");
    // R9: prescaled timer, reload 5, idle high
    runCase(1, 0, 1, 3, 5, 0, 4, "R9");
    // R5: timer reload 0 acts as 1
    runCase(0, 0, 1, 1, 0, 0, 5, "R5");
    summary();
  end

  initial begin
    #(20 * 150000);
    nChk++;
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule